// File: doc/BRIEF.md
# Operand-Timed 16x16 Multiplier

This block multiplies two 16-bit operands into a 32-bit product, in an unsigned or a signed mode, and spends a number of clocks on it that depends on the value of one operand. It recreates the cost of a microcoded multiply instruction. Cores that must match an old processor cycle for cycle need it, because interrupt response waits for the running instruction to end.

A one-cycle start pulse captures the operands and the mode. Busy then stays high for exactly 38 + 2n clocks. Here n is counted from the timing operand (`src_op`). In unsigned mode n is the number of ones in that operand. In signed mode n is the number of value changes between neighbouring bits after a zero is placed below its bit 0. When busy falls, done pulses for one cycle and the product output takes the new value. It holds that value until the next completion.

Top module: `mul_timed`

## Requirements
- R1: With `mode_signed` = 0 the product is the unsigned 32-bit product of `src_op` and `oth_op`.
- R2: With `mode_signed` = 1 the product is the two's complement 32-bit product of both operands read as signed, including 0x8000 x 0x8000 = 0x40000000.
- R3: When start is sampled high at edge E0 with busy low, busy is high for exactly L = 38 + 2n cycles, starting in the cycle after E0. Done is high in the cycle after the last busy cycle, so L ranges from 38 to 70.
- R4: In unsigned mode n is the number of one bits in `src_op`; 0xFFFF gives n = 16 and L = 70.
- R5: In signed mode n is the number of positions i (0..15) where bit i of `src_op` differs from bit i-1, with bit -1 taken as 0; 0x5555 gives n = 16 and L = 70, and 0x0000 gives L = 38.
- R6: A start pulse while busy is high is ignored: neither the running latency nor the product it delivers changes.
- R7: The product output changes only on the edge that raises done and holds its value in every other cycle.
- R8: Done is a single-cycle pulse, never high together with busy. A start in the done cycle is accepted and begins a new operation at once.
- R9: After reset busy is 0, done is 0 and the product output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| mode_signed | input | 1 | 0 unsigned, 1 signed |
| src_op | input | 16 | Timing operand (sets n) |
| oth_op | input | 16 | Second operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 32 | Last completed product |

## Verification
The product update with its done pulse and the capture of the next start can fall in the same cycle. The bench chains operations so that each new start is driven in the cycle where the previous done is seen. It then checks that the earlier product appeared unchanged and that the new operation's product and busy length match the formulas. A start pulse in the middle of a busy period, with different operands, is also judged by the unchanged result and length of the running operation.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic {MODE_UNS = 1'b0, MODE_SGN = 1'b1} mul_mode_e;
endpackage

// File: rtl/mul_lat_calc.sv
module mul_lat_calc #(
  parameter int W    = 16,
  parameter int BASE = 38,
  parameter int STEP = 2,
  localparam int LMAX = BASE + STEP * W,
  localparam int LW   = $clog2(LMAX + 1)
) (
  input  logic          signed_mode,
  input  logic [W-1:0]  src,
  output logic [LW-1:0] lat
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0] mark;
  logic [CW-1:0] n;

  // bit 0 compares against the appended zero
  assign mark[0] = src[0];
  for (genvar i = 1; i < W; i++) begin : g_mark
    assign mark[i] = signed_mode ? (src[i] ^ src[i-1]) : src[i];
  end

  always_comb begin
    n = '0;
    for (int i = 0; i < W; i++) n = n + CW'(mark[i]);
  end

  assign lat = LW'(BASE) + LW'(STEP) * LW'(n);

  always_comb begin
    AST_LAT_RANGE: assert (lat >= LW'(BASE) && lat <= LW'(LMAX)); // R3
  end
endmodule

// File: rtl/mul_prod_unit.sv
module mul_prod_unit #(
  parameter int W = 16,
  localparam int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          signed_mode,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [PW-1:0] prod_q
);
  logic [PW-1:0] ua, ub, sa, sb, p_u, p_s;

  assign ua  = {{W{1'b0}}, a};
  assign ub  = {{W{1'b0}}, b};
  assign sa  = {{W{a[W-1]}}, a};
  assign sb  = {{W{b[W-1]}}, b};
  assign p_u = ua * ub;
  assign p_s = sa * sb;

  always_ff @(posedge clk) begin
    if (rst)       prod_q <= '0;
    else if (load) prod_q <= signed_mode ? p_s : p_u;
  end
endmodule

// File: rtl/mul_seq_ctl.sv
module mul_seq_ctl #(
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [LW-1:0] lat,
  output logic          load,
  output logic          fin,
  output logic          busy,
  output logic          done
);
  logic [LW-1:0] cnt;

  assign load = start && !busy;
  assign fin  = busy && (cnt == LW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= fin;
      if (load) begin
        cnt  <= lat;
        busy <= 1'b1;
      end else if (busy) begin
        cnt <= cnt - LW'(1);
        if (fin) busy <= 1'b0;
      end
    end
  end

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst) !(busy && done)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8
  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst) (start && busy) |=> busy || done); // R6
endmodule

// File: rtl/mul_timed.sv
module mul_timed #(
  parameter int W    = 16,
  parameter int BASE = 38,
  parameter int STEP = 2,
  localparam int PW   = 2 * W,
  localparam int LMAX = BASE + STEP * W,
  localparam int LW   = $clog2(LMAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mode_signed,
  input  logic [W-1:0]  src_op,
  input  logic [W-1:0]  oth_op,
  output logic          busy,
  output logic          done,
  output logic [PW-1:0] product
);
  import mul_pkg::*;

  mul_mode_e     mode;
  logic [LW-1:0] lat;
  logic          load, fin;
  logic [PW-1:0] prod_q;

  assign mode = mul_mode_e'(mode_signed);

  mul_lat_calc #(.W(W), .BASE(BASE), .STEP(STEP)) u_lat (
    .signed_mode(mode == MODE_SGN), .src(src_op), .lat(lat)
  );

  mul_prod_unit #(.W(W)) u_prod (
    .clk(clk), .rst(rst), .load(load), .signed_mode(mode == MODE_SGN),
    .a(src_op), .b(oth_op), .prod_q(prod_q)
  );

  mul_seq_ctl #(.LW(LW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .lat(lat),
    .load(load), .fin(fin), .busy(busy), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst)      product <= '0;
    else if (fin) product <= prod_q;
  end

  AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(product)); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst) (start && busy) |=> $stable(prod_q)); // R6
endmodule

// File: tb/sim_mul_timed.sv
module sim_mul_timed;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mode_signed = 1'b0;
  logic [15:0] src_op = '0, oth_op = '0;
  logic busy, done;
  logic [31:0] product;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mul_timed u0 (.clk(clk), .rst(rst), .start(start), .mode_signed(mode_signed),
                .src_op(src_op), .oth_op(oth_op), .busy(busy), .done(done), .product(product));

  function automatic int exp_n(bit sm, logic [15:0] s);
    int n = 0;
    for (int i = 0; i < 16; i++) begin
      if (sm) n += (s[i] != ((i == 0) ? 1'b0 : s[i-1])) ? 1 : 0;
      else    n += s[i] ? 1 : 0;
    end
    return n;
  endfunction

  function automatic logic [31:0] exp_p(bit sm, logic [15:0] a, logic [15:0] b);
    longint x, y;
    x = sm ? longint'($signed(a)) : longint'(a);
    y = sm ? longint'($signed(b)) : longint'(b);
    return 32'(x * y);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; drives start in the current cycle.
  task automatic run_op(bit sm, logic [15:0] a, logic [15:0] b, bit poke, string req);
    int k = 0;
    int exp_l = 38 + 2 * exp_n(sm, a);
    logic [31:0] exp_v = exp_p(sm, a, b);
    logic [31:0] held = product;
    bit busy_ok = 1;
    start = 1; mode_signed = sm; src_op = a; oth_op = b;
    @(negedge clk);
    start = 0;
    while (!done && k < 200) begin
      k++;
      if (!busy) busy_ok = 0;
      if (product != held) busy_ok = 0;
      if (poke && k == 5) begin start = 1; mode_signed = ~sm; src_op = ~a; oth_op = ~b; end
      else start = 0;
      @(negedge clk);
    end
    start = 0;
    chk(k == exp_l, {req, " latency R3"}, k, exp_l);
    chk(exp_v == product, {req, " product"}, product, exp_v);
    chk(busy_ok && !busy, "R7/R8 busy high and product held until done", busy, 0);
  endtask

  task automatic idle(int c);
    repeat (c) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !done && product == 0, "R9 reset state", {busy, done, product}, 0);
    run_op(0, 16'h1234, 16'h5678, 0, "R1 unsigned basic");  idle(2);
    run_op(0, 16'hFFFF, 16'hFFFF, 0, "R4 unsigned max");    idle(1);
    run_op(0, 16'h0000, 16'hABCD, 0, "R4 unsigned zero");   idle(1);
    run_op(1, 16'h5555, 16'h7FFF, 0, "R5 signed worst");    idle(1);
    run_op(1, 16'h0000, 16'h8000, 0, "R5 signed zero");     idle(1);
    run_op(1, 16'h8000, 16'h8000, 0, "R2 signed min*min");  idle(1);
    run_op(1, 16'hFFFF, 16'h0003, 0, "R2 signed -1");       idle(1);
    run_op(1, 16'h7FFF, 16'h8000, 0, "R2 signed max*min");  idle(1);
    run_op(0, 16'h00F0, 16'h0101, 1, "R6 start while busy"); idle(1);
    // R8: back-to-back, start driven in the done cycle
    run_op(1, 16'hAAAA, 16'h1111, 0, "R8 chain a");
    run_op(0, 16'h8001, 16'hFFFE, 0, "R8 chain b");
    run_op(1, 16'h0F0F, 16'hF00F, 0, "R8 chain c");
    idle(3);
    chk(!done && !busy, "R8 done single pulse", done, 0);
    for (int i = 0; i < 40; i++) begin
      bit sm = 1'($urandom);
      logic [15:0] a = 16'($urandom), b = 16'($urandom);
      run_op(sm, a, b, (i % 7) == 3, sm ? "R2/R5 random" : "R1/R4 random");
      if ($urandom % 2) idle(1 + $urandom % 3);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule